// File: doc/BRIEF.md
# Nested Weighted Memory Request Arbiter

This block decides which of several units may use a shared SDRAM port in the next transaction slot. Each grant covers one 64-byte transfer. The arbiter is a chain of two-way weighted levels. At every level one named unit competes against one entrant that stands for everything deeper in the chain. The deepest level shares its turns among a group of low-rate units. Every competitor has a 3-bit weight, and its share of grants at its level follows its weight relative to the weight of its opponent. A weight of zero disables that competitor.

A refresh timer runs alongside the arbiter and requests a refresh slot at a fixed interval. A pending refresh wins the next slot boundary. It then holds the port for a fixed number of cycles, and no unit is granted during that time. Each unit also has an overflow/underflow report input that sets a sticky exception flag.

The chain order gives the index of each unit on the request, weight and grant buses. Indices 0 to NCHAIN-1 are the named units, from the outermost level (index 0) to the innermost. Indices NCHAIN to NCHAIN+NLEAF-1 are the low-rate units of the deepest level.

Top module: `hwa_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant` is all zero, `refresh` is low and `err_flag` is all zero. Reset loads every credit counter from its weight.
- R2: `grant` has at most one bit set. A bit is set only for a unit that requested with a nonzero weight. A unit with weight 0 is never granted.
- R3: A grant stays unchanged until `done` is high at a clock edge. At that edge `grant` returns to zero, and there is at least one idle cycle before the next grant.
- R4: At each chain level both competitors hold a credit. A competitor is active when it has a request and a nonzero weight (for the deeper entrant, the weight in `agg_wt` and at least one active unit below it). Among the active competitors, the named unit wins if it has credit left; otherwise the deeper entrant wins if it has credit. When no active competitor has credit, both credits are reloaded from their weights before the choice is made. Each grant takes one credit from the winner at every level on its path.
- R5: Competitors that are idle or disabled never block an active one. A lone active requester is granted at every slot, whatever its credit.
- R6: At the deepest level, the grant goes to the lowest-index active low-rate unit that has credit. When no active unit has credit, all low-rate credits are reloaded from their weights first.
- R7: A refresh becomes pending every REF_INTERVAL cycles. With no traffic, `refresh` first rises REF_INTERVAL+1 cycles after reset is released.
- R8: A pending refresh wins over all unit requests at a slot boundary. `refresh` then stays high for exactly REF_LEN cycles with `grant` at zero, and a waiting request is granted one cycle after `refresh` falls.
- R9: A high `err_in` bit sets the matching `err_flag` bit at the next edge. The bit stays set until reset.
- R10: From an idle state with no pending refresh, a request present at a clock edge shows up on `grant` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NU | Request line per unit |
| unit_wt | input | NU x WW | Weight of each unit at its own level |
| agg_wt | input | NCHAIN x WW | Weight of the deeper entrant at each chain level |
| done | input | 1 | Memory side finished the granted transaction |
| err_in | input | NU | Overflow/underflow report per unit |
| grant | output | NU | One-hot grant, registered |
| refresh | output | 1 | Refresh slot in progress, registered |
| err_flag | output | NU | Sticky exception flag per unit |

## Verification
A grant appears one cycle after the bench presents requests to an idle arbiter, or one cycle after `refresh` falls. The bench drives inputs on the falling edge and reads outputs on the next falling edge. When a refresh gets in the way, it waits, and it checks the one-cycle latency only for slots that no refresh disturbed. The grant must drop one cycle after `done`, and the bench checks that at the following falling edge. Refresh start is counted in cycles from reset release, and refresh length is counted in cycles at the outputs. An error flag is sampled one cycle after its report pulse.

// File: rtl/hwa_pkg.sv
package hwa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANT   = 2'd1,
    ST_REFRESH = 2'd2
  } arb_state_e;
endpackage

// File: rtl/hwa_level.sv
// One two-way weighted stage: a named unit against the deeper entrant.
module hwa_level #(
  parameter int WW = 3
) (
  input  logic          act_n,
  input  logic          act_a,
  input  logic [WW-1:0] cred_n,
  input  logic [WW-1:0] cred_a,
  input  logic [WW-1:0] w_n,
  input  logic [WW-1:0] w_a,
  output logic          pick_n,
  output logic          pick_a,
  output logic [WW-1:0] nxt_n,
  output logic [WW-1:0] nxt_a
);
  logic          any_cr;
  logic [WW-1:0] eff_n, eff_a;

  always_comb begin
    any_cr = (act_n && cred_n != '0) || (act_a && cred_a != '0);
    eff_n  = any_cr ? cred_n : w_n;
    eff_a  = any_cr ? cred_a : w_a;
    pick_n = act_n && (eff_n != '0);
    pick_a = !pick_n && act_a && (eff_a != '0);
    nxt_n  = pick_n ? eff_n - WW'(1) : eff_n;
    nxt_a  = pick_a ? eff_a - WW'(1) : eff_a;
  end
endmodule

// File: rtl/hwa_leaf.sv
// Deepest stage: credit sharing among the low-rate units.
module hwa_leaf #(
  parameter int N  = 4,
  parameter int WW = 3
) (
  input  logic [N-1:0]         act,
  input  logic [N-1:0][WW-1:0] cred,
  input  logic [N-1:0][WW-1:0] w,
  output logic [N-1:0]         pick,
  output logic [N-1:0][WW-1:0] nxt
);
  logic                any_cr;
  logic                found;
  logic [N-1:0][WW-1:0] eff;

  always_comb begin
    any_cr = 1'b0;
    for (int j = 0; j < N; j++)
      if (act[j] && cred[j] != '0) any_cr = 1'b1;
    found = 1'b0;
    pick  = '0;
    for (int j = 0; j < N; j++) begin
      eff[j] = any_cr ? cred[j] : w[j];
      if (!found && act[j] && eff[j] != '0) begin
        pick[j] = 1'b1;
        found   = 1'b1;
      end
      nxt[j] = pick[j] ? eff[j] - WW'(1) : eff[j];
    end
  end
endmodule

// File: rtl/hwa_refresh.sv
// Free-running refresh interval timer with a pending flag.
module hwa_refresh #(
  parameter int INTERVAL = 1220
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + CW'(1);
      if (wrap)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/hwa_arbiter.sv
module hwa_arbiter
  import hwa_pkg::*;
#(
  parameter int NCHAIN       = 5,
  parameter int NLEAF        = 4,
  parameter int WW           = 3,
  parameter int REF_INTERVAL = 1220,
  parameter int REF_LEN      = 19,
  localparam int NU          = NCHAIN + NLEAF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NU-1:0]         req,
  input  logic [NU-1:0][WW-1:0] unit_wt,
  input  logic [NCHAIN-1:0][WW-1:0] agg_wt,
  input  logic                  done,
  input  logic [NU-1:0]         err_in,
  output logic [NU-1:0]         grant,
  output logic                  refresh,
  output logic [NU-1:0]         err_flag
);
  localparam int RLW = $clog2(REF_LEN + 1);

  arb_state_e            state;
  logic [RLW-1:0]        rlen;
  logic                  pend, take, slot_go;
  logic [NCHAIN:0]       lvl_act;
  logic [NCHAIN:0]       path;
  logic [NCHAIN-1:0]     pick_n, pick_a;
  logic [NU-1:0]         gnt_nxt;
  logic [NLEAF-1:0]      leaf_act, leaf_pick;
  logic [NLEAF-1:0][WW-1:0] leaf_cred, leaf_nxt, leaf_w;

  assign take    = (state == ST_IDLE) && pend;
  assign slot_go = (state == ST_IDLE) && !pend && lvl_act[0];
  assign path[0] = 1'b1;

  // Low-rate group
  genvar j;
  generate
    for (j = 0; j < NLEAF; j++) begin : g_leaf
      assign leaf_w[j]   = unit_wt[NCHAIN + j];
      assign leaf_act[j] = req[NCHAIN + j] && (unit_wt[NCHAIN + j] != '0);
      always_ff @(posedge clk) begin
        if (rst)                          leaf_cred[j] <= unit_wt[NCHAIN + j];
        else if (slot_go && path[NCHAIN]) leaf_cred[j] <= leaf_nxt[j];
      end
      assign gnt_nxt[NCHAIN + j] = path[NCHAIN] && leaf_pick[j];
    end
  endgenerate

  assign lvl_act[NCHAIN] = |leaf_act;

  hwa_leaf #(.N(NLEAF), .WW(WW)) leaf_i (
    .act(leaf_act), .cred(leaf_cred), .w(leaf_w),
    .pick(leaf_pick), .nxt(leaf_nxt)
  );

  // Chain of two-way levels
  genvar i;
  generate
    for (i = 0; i < NCHAIN; i++) begin : g_lvl
      logic          an, aa;
      logic [WW-1:0] cn_q, ca_q, nn, na;
      assign an         = req[i] && (unit_wt[i] != '0);
      assign aa         = lvl_act[i+1] && (agg_wt[i] != '0);
      assign lvl_act[i] = an || aa;

      hwa_level #(.WW(WW)) lvl_i (
        .act_n(an), .act_a(aa), .cred_n(cn_q), .cred_a(ca_q),
        .w_n(unit_wt[i]), .w_a(agg_wt[i]),
        .pick_n(pick_n[i]), .pick_a(pick_a[i]), .nxt_n(nn), .nxt_a(na)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          cn_q <= unit_wt[i];
          ca_q <= agg_wt[i];
        end else if (slot_go && path[i]) begin
          cn_q <= nn;
          ca_q <= na;
        end
      end

      assign path[i+1]  = path[i] && pick_a[i];
      assign gnt_nxt[i] = path[i] && pick_n[i];
    end
  endgenerate

  hwa_refresh #(.INTERVAL(REF_INTERVAL)) ref_i (
    .clk(clk), .rst(rst), .take(take), .pend(pend)
  );

  // Slot sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      grant   <= '0;
      refresh <= 1'b0;
      rlen    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pend) begin
            state   <= ST_REFRESH;
            refresh <= 1'b1;
            rlen    <= RLW'(REF_LEN - 1);
          end else if (lvl_act[0]) begin
            state <= ST_GRANT;
            grant <= gnt_nxt;
          end
        end
        ST_GRANT: begin
          if (done) begin
            state <= ST_IDLE;
            grant <= '0;
          end
        end
        ST_REFRESH: begin
          if (rlen == '0) begin
            state   <= ST_IDLE;
            refresh <= 1'b0;
          end else begin
            rlen <= rlen - RLW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_flag <= '0;
    else     err_flag <= err_flag | err_in;
  end
endmodule

// File: rtl/hwa_chk.sv
module hwa_chk #(
  parameter int NU      = 9,
  parameter int WW      = 3,
  parameter int REF_LEN = 19
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NU-1:0]         req,
  input logic [NU-1:0][WW-1:0] unit_wt,
  input logic                  done,
  input logic [NU-1:0]         err_in,
  input logic [NU-1:0]         grant,
  input logic                  refresh,
  input logic [NU-1:0]         err_flag
);
  localparam int RCW = $clog2(REF_LEN + 2);
  logic [RCW-1:0] rc;

  always_ff @(posedge clk) begin
    if (rst)          rc <= '0;
    else if (refresh) rc <= rc + RCW'(1);
    else              rc <= '0;
  end

  // R2
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R8
  a_r8_no_grant_in_refresh: assert property (@(posedge clk) disable iff (rst)
    refresh |-> (grant == '0));
  a_r8_len: assert property (@(posedge clk) disable iff (rst)
    refresh |-> (rc < RCW'(REF_LEN)));
  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    ((grant != '0) && !done) |=> (grant == $past(grant)));
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    ((grant != '0) && done) |=> (grant == '0));

  genvar k;
  generate
    for (k = 0; k < NU; k++) begin : g_bit
      // R2
      a_r2_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(grant[k]) |-> ($past(req[k]) && ($past(unit_wt[k]) != '0)));
      // R9
      a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag[k] |=> err_flag[k]);
      a_r9_set: assert property (@(posedge clk) disable iff (rst)
        err_in[k] |=> err_flag[k]);
    end
  endgenerate
endmodule

bind hwa_arbiter hwa_chk #(.NU(NU), .WW(WW), .REF_LEN(REF_LEN)) chk_i (
  .clk(clk), .rst(rst), .req(req), .unit_wt(unit_wt), .done(done),
  .err_in(err_in), .grant(grant), .refresh(refresh), .err_flag(err_flag)
);

// File: tb/hwa_arbiter_tb.sv
module hwa_arbiter_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int NCHAIN       = 5;
  localparam int NLEAF        = 4;
  localparam int NU           = NCHAIN + NLEAF;
  localparam int WW           = 3;
  localparam int REF_INTERVAL = 300;
  localparam int REF_LEN      = 19;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic [NU-1:0]             req = '0;
  logic [NU-1:0][WW-1:0]     unit_wt = '0;
  logic [NCHAIN-1:0][WW-1:0] agg_wt = '0;
  logic                      done = 1'b0;
  logic [NU-1:0]             err_in = '0;
  logic [NU-1:0]             grant;
  logic                      refresh;
  logic [NU-1:0]             err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  int mc_n [NCHAIN];
  int mc_a [NCHAIN];
  int mc_l [NLEAF];

  always #(CLK_PERIOD/2) clk = ~clk;

  hwa_arbiter #(
    .NCHAIN(NCHAIN), .NLEAF(NLEAF), .WW(WW),
    .REF_INTERVAL(REF_INTERVAL), .REF_LEN(REF_LEN)
  ) dut_i (
    .clk(clk), .rst(rst), .req(req), .unit_wt(unit_wt), .agg_wt(agg_wt),
    .done(done), .err_in(err_in), .grant(grant), .refresh(refresh),
    .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Reference model of the credit rules (R4, R5, R6)
  task automatic model_reset();
    for (int i = 0; i < NCHAIN; i++) begin
      mc_n[i] = int'(unit_wt[i]);
      mc_a[i] = int'(agg_wt[i]);
    end
    for (int j = 0; j < NLEAF; j++) mc_l[j] = int'(unit_wt[NCHAIN + j]);
  endtask

  task automatic model_pick(input logic [NU-1:0] r, output logic [NU-1:0] g);
    bit act_l [NLEAF];
    bit an [NCHAIN];
    bit aa [NCHAIN];
    bit below;
    bit anycr;
    bit reach;
    int en, ea;
    int el [NLEAF];
    g = '0;
    below = 1'b0;
    for (int j = 0; j < NLEAF; j++) begin
      act_l[j] = r[NCHAIN + j] && unit_wt[NCHAIN + j] != 0;
      if (act_l[j]) below = 1'b1;
    end
    for (int i = NCHAIN - 1; i >= 0; i--) begin
      an[i] = r[i] && unit_wt[i] != 0;
      aa[i] = below && agg_wt[i] != 0;
      below = an[i] || aa[i];
    end
    if (!below) return;
    reach = 1'b1;
    for (int i = 0; i < NCHAIN && reach; i++) begin
      anycr = (an[i] && mc_n[i] > 0) || (aa[i] && mc_a[i] > 0);
      en = anycr ? mc_n[i] : int'(unit_wt[i]);
      ea = anycr ? mc_a[i] : int'(agg_wt[i]);
      if (an[i] && en > 0) begin
        g[i] = 1'b1; mc_n[i] = en - 1; mc_a[i] = ea; reach = 1'b0;
      end else begin
        mc_n[i] = en; mc_a[i] = ea - 1;
      end
    end
    if (reach) begin
      anycr = 1'b0;
      for (int j = 0; j < NLEAF; j++) if (act_l[j] && mc_l[j] > 0) anycr = 1'b1;
      for (int j = 0; j < NLEAF; j++) el[j] = anycr ? mc_l[j] : int'(unit_wt[NCHAIN + j]);
      for (int j = 0; j < NLEAF; j++) begin
        if (act_l[j] && el[j] > 0 && reach) begin
          g[NCHAIN + j] = 1'b1; el[j] = el[j] - 1; reach = 1'b0;
        end
        mc_l[j] = el[j];
      end
    end
  endtask

  // One transaction slot: present requests at a falling edge, check the grant.
  task automatic do_slot(input logic [NU-1:0] r, input string tag);
    logic [NU-1:0] exp;
    int  waited;
    bit  saw_ref;
    req = r;
    model_pick(r, exp);
    if (exp == '0) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        check(grant == '0, {tag, " idle"}, int'(grant), 0);
      end
      return;
    end
    waited = 0;
    saw_ref = 1'b0;
    do begin
      @(negedge clk);
      waited++;
      if (refresh) saw_ref = 1'b1;
    end while (grant == '0 && waited < 60);
    check(grant == exp, tag, int'(grant), int'(exp));
    if (!saw_ref) check(waited == 1, "R10 latency", waited, 1);
    for (int c = 0; c < int'($urandom % 3); c++) begin
      @(negedge clk);
      check(grant == exp, "R3 hold", int'(grant), int'(exp));
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check(grant == '0, "R3 release", int'(grant), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NU-1:0] g;
    int cnt;
    int rl;
    void'($urandom(32'd1234));
    // Weights: named 1,1,2,2,2 ; deeper 2,1,1,1,1 ; leaves 1,2,0,3
    unit_wt[0] = 3'd1; unit_wt[1] = 3'd1; unit_wt[2] = 3'd2;
    unit_wt[3] = 3'd2; unit_wt[4] = 3'd2;
    unit_wt[5] = 3'd1; unit_wt[6] = 3'd2; unit_wt[7] = 3'd0; unit_wt[8] = 3'd3;
    agg_wt[0] = 3'd2; agg_wt[1] = 3'd1; agg_wt[2] = 3'd1;
    agg_wt[3] = 3'd1; agg_wt[4] = 3'd1;
    repeat (3) @(negedge clk);
    check(grant == '0,    "R1 grant",   int'(grant), 0);
    check(refresh == 1'b0, "R1 refresh", int'(refresh), 0);
    check(err_flag == '0, "R1 errflag", int'(err_flag), 0);
    model_reset();
    rst = 1'b0;

    // R7: first refresh with no traffic
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!refresh && cnt < REF_INTERVAL + 10);
    check(cnt == REF_INTERVAL + 1, "R7 first refresh", cnt, REF_INTERVAL + 1);
    // R8: length, no grant, request waits
    req = NU'(1);
    rl = 0;
    while (refresh) begin
      rl++;
      check(grant == '0, "R8 grant during refresh", int'(grant), 0);
      @(negedge clk);
    end
    check(rl == REF_LEN, "R8 refresh length", rl, REF_LEN);
    check(grant == '0, "R8 gap after refresh", int'(grant), 0);
    model_pick(req, g);
    @(negedge clk);
    check(grant == g, "R8 grant after refresh", int'(grant), int'(g));
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;

    // R4: all requesting, nested credit order
    for (int s = 0; s < 12; s++) do_slot('1, "R4 all requesting");
    // R5: lone requester with weight 1 keeps winning
    for (int s = 0; s < 4; s++) do_slot(NU'(1), "R5 lone outer unit");
    do_slot(NU'(1) << 4, "R5 lone inner unit");
    // R2: only the disabled leaf requests
    do_slot(NU'(1) << (NCHAIN + 2), "R2 zero weight");
    // R6: leaf sharing among indices 0, 1 and 3 (weights 1,2,3)
    for (int s = 0; s < 8; s++) do_slot(NU'(11) << NCHAIN, "R6 leaf share");

    // Random traffic, weights refreshed in blocks
    for (int b = 0; b < 8; b++) begin
      for (int u = 0; u < NU; u++) unit_wt[u] = WW'($urandom % 8);
      for (int l = 0; l < NCHAIN; l++) agg_wt[l] = WW'($urandom % 8);
      for (int s = 0; s < 40; s++) do_slot(NU'($urandom), "R4 random");
    end

    // R9: sticky flag
    @(negedge clk);
    err_in = NU'(1) << 3;
    @(negedge clk);
    err_in = '0;
    check(err_flag == (NU'(1) << 3), "R9 set", int'(err_flag), 8);
    repeat (5) @(negedge clk);
    check(err_flag == (NU'(1) << 3), "R9 sticky", int'(err_flag), 8);

    finish_run();
  end
endmodule